// File: doc/BRIEF.md
# Four-Tap Transposed FIR Bring-Up Filter

This block is a small fixed-length FIR filter meant as a first design to load when a new prototyping board is being commissioned. It runs on one clock with one synchronous reset, takes 8-bit unsigned samples and 8-bit unsigned coefficients, and produces the exact sum with no rounding or clipping. The filter is built in transposed form. Every tap multiplies the current sample by its own coefficient, adds the registered partial sum passed along from the next tap, and registers the result. Because of this, the chain can be cut between any two taps and spread over several devices without any combinational path crossing a cut.

The four coefficients sit in registers that are written at run time through a small load port. A select input switches the sample source to a built-in impulse source. That source produces a single unit sample on the first clock after reset and zero after that. The output then plays the four coefficients back one per clock, in tap order, and then stays at zero. If the coefficients are loaded with four distinct values, a logic analyser on the output shows whether the whole chain, including any cuts between devices, is wired and timed correctly.

Top module: `tfir_selftest`

## Requirements
- R1: While `use_impulse` is 0, the output after clock edge n equals c0·x(n) + c1·x(n−1) + c2·x(n−2) + c3·x(n−3). Here x(n) is `sample_in` captured at edge n, ck is coefficient k, all values are unsigned, and samples captured before the last reset count as zero.
- R2: `sum_out` is 18 bits wide and is never truncated. With all coefficients and all samples at 255, it reaches 260100.
- R3: While `use_impulse` is 1, the sample fed to the taps is 1 at the first clock edge after reset is released and 0 at every later edge. `sample_in` has no effect in this mode.
- R4: With `use_impulse` held at 1 through a reset release, `sum_out` shows c0, c1, c2 and c3 after edges 1, 2, 3 and 4 following the release, and 0 after every later edge.
- R5: A clock edge with `coef_wr`=1 and `use_impulse`=0 stores `coef_data` into coefficient `coef_idx`, where index 0 weights the newest sample. A sample captured at that same edge still uses the old value. Samples captured at later edges use the new value.
- R6: Coefficient writes are ignored while `use_impulse` is 1.
- R7: Reset clears every partial sum, so `sum_out` is 0 after any edge at which reset is high. Reset leaves the coefficients unchanged, and coefficient writes are accepted during reset.
- R8: `out_valid` is 0 while reset is high. It goes to 1 after the first edge following reset release and stays at 1 until the next reset.
- R9: `sum_out` changes only at clock edges. A change on `sample_in` between edges does not reach the output before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| use_impulse | input | 1 | 1 selects the built-in impulse source and blocks coefficient writes |
| sample_in | input | 8 | External unsigned sample |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_idx | input | 2 | Coefficient index for a write (0 weights the newest sample) |
| coef_data | input | 8 | Unsigned coefficient value for a write |
| sum_out | output | 18 | Full-precision filter output |
| out_valid | output | 1 | High from the first edge after reset release |

## Verification
The bench targets the impulse playback order. A chain wired the wrong way round would play the coefficients back reversed, and an impulse generator that fires twice or too late would shift or repeat them. It writes a coefficient in self-test mode and then replays the impulse after a second reset. A design that accepted the write would show the changed value, and one that cleared coefficients on reset would play back zeros. It also changes a coefficient at the same edge as a nonzero sample, to catch a product that uses the new value one cycle early. Finally, it drives the largest operands, which a narrower sum would wrap, and moves `sample_in` between edges to catch a combinational leak to the output.

// File: rtl/tfir_pkg.sv
package tfir_pkg;

  parameter int FIR_TAPS = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic [FIR_TAPS-1:0] coefLoad;   // one-hot write enable per coefficient
    logic                impulse;    // unit sample from the self-test source
    logic                useImpulse; // sample source select
  } tfirStrobe_t;

endpackage

// File: rtl/tfir_tap.sv
module tfir_tap #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int SUM_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0] coef,
  input  logic [SUM_W-1:0]  sumIn,
  output logic [SUM_W-1:0]  sumOut
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic [PROD_W-1:0] product;

  assign product = PROD_W'(sample) * PROD_W'(coef);

  always_ff @(posedge clk) begin
    if (rst) sumOut <= '0;
    else     sumOut <= sumIn + SUM_W'(product);
  end

  // R7: reset clears the tap register
  a_r7_tap_cleared: assert property (@(posedge clk) rst |=> (sumOut == '0));

  // R2: unsigned accumulate never wraps below the incoming partial sum
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sumOut >= $past(sumIn)));

endmodule

// File: rtl/tfir_ctrl.sv
module tfir_ctrl
  import tfir_pkg::*;
#(
  parameter int NTAPS = FIR_TAPS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     useImpulse,
  input  logic                     coefWr,
  input  logic [$clog2(NTAPS)-1:0] coefIdx,
  output tfirStrobe_t              strobe,
  output logic                     outValid
);

  localparam int IDX_W = $clog2(NTAPS);

  logic started;

  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  assign outValid          = started;
  assign strobe.useImpulse = useImpulse;
  assign strobe.impulse    = useImpulse & ~started & ~rst;

  for (genvar k = 0; k < NTAPS; k++) begin : g_load
    assign strobe.coefLoad[k] = coefWr & ~useImpulse & (coefIdx == IDX_W'(k));
  end

  // R3: the unit sample is never offered on two edges in a row
  a_r3_single_impulse: assert property (@(posedge clk) disable iff (rst)
    strobe.impulse |=> !strobe.impulse);

  // R8: valid holds until the next reset
  a_r8_valid_holds: assert property (@(posedge clk) disable iff (rst)
    outValid |=> outValid);

  // R8: valid is low right after a reset edge
  a_r8_valid_low_in_reset: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/tfir_datapath.sv
module tfir_datapath
  import tfir_pkg::*;
#(
  parameter int NTAPS  = FIR_TAPS,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int SUM_W  = DATA_W + COEF_W + $clog2(NTAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  tfirStrobe_t       strobe,
  input  logic [COEF_W-1:0] coefData,
  input  logic [DATA_W-1:0] sampleIn,
  output logic [SUM_W-1:0]  sumOut
);

  logic [COEF_W-1:0] coefBank [NTAPS];
  logic [SUM_W-1:0]  partial  [NTAPS+1];
  logic [DATA_W-1:0] tapSample;

  // Sample source select: external stream or self-test unit sample
  assign tapSample = strobe.useImpulse ? DATA_W'(strobe.impulse) : sampleIn;

  // Far end of the chain has no neighbour
  assign partial[NTAPS] = '0;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    // Coefficient register, deliberately outside reset
    always_ff @(posedge clk) begin
      if (strobe.coefLoad[k]) coefBank[k] <= coefData;
    end

    tfir_tap #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .SUM_W (SUM_W)
    ) u_tap (
      .clk   (clk),
      .rst   (rst),
      .sample(tapSample),
      .coef  (coefBank[k]),
      .sumIn (partial[k+1]),
      .sumOut(partial[k])
    );

    // R6: coefficients hold while self-test mode is selected
    a_r6_coef_frozen: assert property (@(posedge clk)
      strobe.useImpulse |=> $stable(coefBank[k]));
  end

  assign sumOut = partial[0];

  // R5: at most one coefficient written per edge
  a_r5_one_write: assert property (@(posedge clk) $onehot0(strobe.coefLoad));

endmodule

// File: rtl/tfir_selftest.sv
module tfir_selftest
  import tfir_pkg::*;
#(
  parameter int NTAPS  = FIR_TAPS,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int SUM_W  = DATA_W + COEF_W + $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     use_impulse,
  input  logic [DATA_W-1:0]        sample_in,
  input  logic                     coef_wr,
  input  logic [$clog2(NTAPS)-1:0] coef_idx,
  input  logic [COEF_W-1:0]        coef_data,
  output logic [SUM_W-1:0]         sum_out,
  output logic                     out_valid
);

  tfirStrobe_t strobe;

  tfir_ctrl #(.NTAPS(NTAPS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .useImpulse(use_impulse),
    .coefWr    (coef_wr),
    .coefIdx   (coef_idx),
    .strobe    (strobe),
    .outValid  (out_valid)
  );

  tfir_datapath #(
    .NTAPS (NTAPS),
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .SUM_W (SUM_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .coefData(coef_data),
    .sampleIn(sample_in),
    .sumOut  (sum_out)
  );

endmodule

// File: tb/tb_tfir_selftest.sv
module tb_tfir_selftest;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        use_impulse = 1'b0;
  logic [7:0]  sample_in = '0;
  logic        coef_wr = 1'b0;
  logic [1:0]  coef_idx = '0;
  logic [7:0]  coef_data = '0;
  logic [17:0] sum_out;
  logic        out_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int cf   [4];
  int hist [4];

  localparam logic [7:0] TBL_X [8] = '{8'd10, 8'd20, 8'd0, 8'd255, 8'd255, 8'd255, 8'd255, 8'd1};
  localparam int         TBL_Y [8] = '{20, 70, 110, 680, 1415, 2550, 4335, 3827};

  tfir_selftest dut (
    .clk(clk), .rst(rst), .use_impulse(use_impulse), .sample_in(sample_in),
    .coef_wr(coef_wr), .coef_idx(coef_idx), .coef_data(coef_data),
    .sum_out(sum_out), .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadCoef(input int idx, input int val);
    coef_wr = 1'b1; coef_idx = 2'(idx); coef_data = 8'(val);
    @(negedge clk);
    coef_wr = 1'b0;
  endtask

  function automatic int refStep(input int x);
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    refStep = 0;
    for (int k = 0; k < 4; k++) refStep += cf[k] * hist[k];
  endfunction

  initial begin
    int y0;
    // Reset state, coefficient load during reset
    repeat (2) @(negedge clk);
    cf = '{17, 34, 51, 68};
    for (int k = 0; k < 4; k++) loadCoef(k, cf[k]);
    check("R8 valid low in reset", int'(out_valid), 0);
    check("R7 output zero in reset", int'(sum_out), 0);

    // Impulse self-test with a nonzero external sample that must be ignored
    use_impulse = 1'b1; sample_in = 8'hAA;
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 0) check("R8 valid after first edge", int'(out_valid), 1);
      check("R4 impulse playback", int'(sum_out), (i < 4) ? cf[i] : 0);
      if (i == 1) begin coef_wr = 1'b1; coef_idx = 2'd1; coef_data = 8'd99; end
      else coef_wr = 1'b0;
    end
    check("R3 external sample ignored", int'(sum_out), 0);

    // Reset again: sums cleared, coefficients kept, write above ignored
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset clears sum", int'(sum_out), 0);
    check("R8 valid low after reset", int'(out_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R6 R7 replay keeps coefficients", int'(sum_out), (i < 4) ? cf[i] : 0);
    end

    // External stream with table vectors
    rst = 1'b1; use_impulse = 1'b0; sample_in = '0;
    cf = '{2, 3, 5, 7};
    for (int k = 0; k < 4; k++) loadCoef(k, cf[k]);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sample_in = TBL_X[i];
      @(negedge clk);
      check("R1 table vector", int'(sum_out), TBL_Y[i]);
    end
    sample_in = '0;
    repeat (4) @(negedge clk);
    check("R1 flushed to zero", int'(sum_out), 0);

    // Coefficient write at the same edge as a sample
    coef_wr = 1'b1; coef_idx = 2'd0; coef_data = 8'd9; sample_in = 8'd1;
    @(negedge clk);
    coef_wr = 1'b0;
    check("R5 same-edge sample uses old coefficient", int'(sum_out), 2);
    @(negedge clk);
    check("R5 next sample uses new coefficient", int'(sum_out), 9 + 3);
    sample_in = '0;
    repeat (4) @(negedge clk);

    // No combinational path from input to output
    y0 = int'(sum_out);
    sample_in = 8'd200;
    #3;
    check("R9 output held between edges", int'(sum_out), y0);
    @(negedge clk);
    check("R9 output after edge", int'(sum_out), 9 * 200);
    sample_in = '0;
    repeat (4) @(negedge clk);

    // Largest operands
    for (int k = 0; k < 4; k++) loadCoef(k, 255);
    sample_in = 8'd255;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R2 full precision sum", int'(sum_out), 65025 * i);
    end
    sample_in = '0;

    // Random stream against a convolution model
    rst = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cf[k] = int'($urandom_range(0, 255));
      loadCoef(k, cf[k]);
    end
    rst = 1'b0;
    hist = '{0, 0, 0, 0};
    for (int i = 0; i < 300; i++) begin
      int x;
      x = int'($urandom_range(0, 255));
      sample_in = 8'(x);
      @(negedge clk);
      check("R1 random stream", int'(sum_out), refStep(x));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule